// File: doc/BRIEF.md
# Pipelined-Carry Binary Counter with Deskewed Snapshot

This block is a wide free-running binary counter built so that its clock rate does not drop as the width grows. Every bit stage has two flops. One holds the count bit. The other holds the carry that the stage passes to the stage above it. The only logic between any two flops is a single two-input gate. Because the carry is registered, a carry takes one clock to move up each stage. As a result, bit i of the internal register shows the count from i cycles earlier.

A snapshot path undoes that skew. A single-cycle request pulse samples the count as it stood in the cycle of the request. Each bit is held in a delay line whose length is chosen so that all bits line up in the same cycle. The aligned word is then loaded into an output register, and a one-cycle valid flag marks it. Requests may arrive on every cycle, and each one produces its own snapshot. A synchronous clear empties the counter, all carries, the snapshot register and any requests still in flight.

Top module: `pipecarry_counter`

## Requirements
- R1: A request sampled high in cycle t yields a snapshot equal to the number of earlier cycles since the last clear in which the enable was high, modulo 2^W. The enable in cycle t itself is not counted.
- R2: A count bit changes only in the cycle after the carry into its stage was set. The carry into bit 0 is the enable input.
- R3: Each stage's carry flop stays set for at most one cycle in a row. Snapshots stay exact when the request falls while carries are still rippling up the stages.
- R4: The valid flag is high exactly W cycles after the cycle of the request, for one cycle per request. It is never high otherwise.
- R5: Requests in consecutive cycles produce valid snapshots in consecutive cycles, each one with its own count.
- R6: While clear is high, the count bits, the carry flops, the snapshot value and the valid flag all go to zero at the next edge. A request made in the clear cycle, or in the W-1 cycles before it, produces no valid.
- R7: One enabled cycle from the all-ones count gives zero. The carry out of the top bit is dropped.
- R8: The snapshot value holds steady in every cycle in which the valid flag is low, except in the cycle just after a clear.
- R9: While the enable is low, the count does not advance. Snapshots taken across a stretch of low enable all report the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all flops update on the rising edge |
| clr | input | 1 | Synchronous clear of count, carries, snapshot and pending requests |
| en | input | 1 | Count enable; acts as the carry into bit 0 |
| snap_req | input | 1 | One-cycle snapshot request |
| snap_val | output | W | Deskewed count taken at the request cycle |
| snap_vld | output | 1 | High for one cycle when snap_val carries a new snapshot |

## Verification
The assertions assume that clear is held high through the first edges, so that every flop starts from a known zero. They also assume that all inputs change away from the rising edge. The carry and toggle properties further rely on the enable being the only source of carries into the chain. The stimulus raises clear at time zero before any other input is driven, and it changes the enable, the request and the clear only on falling edges. The stimulus also places requests just after wrap points and power-of-two boundaries. At those points the upper bits are still waiting on carries, so skew that is not undone shows up as a wrong snapshot.

// File: rtl/pipecarry_counter.sv
module pipecarry_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic         snap_req,
  output logic [W-1:0] snap_val,
  output logic         snap_vld
);

  logic [W-1:0] bits;
  logic [W-1:0] cry;
  logic [W-1:0] cin;
  logic [W-1:0] aligned;
  logic [W-2:0] req_pipe;

  assign cin = {cry[W-2:0], en};

  always_ff @(posedge clk) begin
    if (clr) begin
      bits <= '0;
      cry  <= '0;
    end else begin
      bits <= bits ^ cin;
      cry  <= cin & bits;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) req_pipe <= '0;
    else     req_pipe <= {req_pipe[W-3:0], snap_req};
  end

  for (genvar i = 0; i < W; i++) begin : g_deskew
    localparam int D = W - 1 - i;
    if (D == 0) begin : g_direct
      assign aligned[i] = bits[i];
    end else begin : g_delay
      logic [D-1:0] sh;
      always_ff @(posedge clk) begin
        sh[0] <= bits[i];
        for (int k = 1; k < D; k++) sh[k] <= sh[k-1];
      end
      assign aligned[i] = sh[D-1];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      snap_val <= '0;
      snap_vld <= 1'b0;
    end else begin
      snap_vld <= req_pipe[W-2];
      if (req_pipe[W-2]) snap_val <= aligned;
    end
  end

endmodule

// File: rtl/pipecarry_counter_chk.sv
module pipecarry_counter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         clr,
  input logic         en,
  input logic [W-1:0] bits,
  input logic [W-1:0] cry,
  input logic [W-1:0] snap_val,
  input logic         snap_vld
);

  AST_CLR_ZERO: assert property (@(posedge clk) $past(clr) |-> (bits == '0 && cry == '0 && !snap_vld && snap_val == '0)) else $error("clear did not empty state"); // R6

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (clr) (!snap_vld && !$past(clr)) |-> $stable(snap_val)) else $error("snapshot moved without valid"); // R8

  AST_BIT0_ADVANCE: assert property (@(posedge clk) disable iff (clr) (!$past(clr) && bits[0] != $past(bits[0])) |-> $past(en)) else $error("bit 0 moved without enable"); // R2

  for (genvar i = 0; i < W; i++) begin : g_cry
    AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (clr) cry[i] |=> !cry[i]) else $error("carry held two cycles"); // R3
  end

  for (genvar i = 1; i < W; i++) begin : g_adv
    AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (clr) (!$past(clr) && bits[i] != $past(bits[i])) |-> $past(cry[i-1])) else $error("bit moved without carry"); // R2
  end

endmodule

bind pipecarry_counter pipecarry_counter_chk #(.W(W)) chk_i (
  .clk(clk), .clr(clr), .en(en), .bits(bits), .cry(cry),
  .snap_val(snap_val), .snap_vld(snap_vld)
);

// File: tb/pipecarry_counter_tb_top.sv
module pipecarry_counter_tb_top;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic en = 1'b0;
  logic snap_req = 1'b0;
  logic [TW-1:0] snap_val;
  logic snap_vld;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pipecarry_counter #(.W(TW)) dut_i (
    .clk(clk), .clr(clr), .en(en), .snap_req(snap_req),
    .snap_val(snap_val), .snap_vld(snap_vld)
  );

  // reference: plain counter plus request history, from the requirements
  logic [TW-1:0] ref_cnt;
  logic          h_stb [0:TW-1];
  logic [TW-1:0] h_val [0:TW-1];
  logic [TW-1:0] exp_hold;

  always @(posedge clk) begin
    if (clr) begin
      ref_cnt  <= '0;
      exp_hold <= '0;
      for (int k = 0; k < TW; k++) begin
        h_stb[k] <= 1'b0;
        h_val[k] <= '0;
      end
    end else begin
      if (en) ref_cnt <= ref_cnt + 1'b1;
      if (h_stb[TW-2]) exp_hold <= h_val[TW-2];
      h_stb[0] <= snap_req;
      h_val[0] <= ref_cnt;
      for (int k = 1; k < TW; k++) begin
        h_stb[k] <= h_stb[k-1];
        h_val[k] <= h_val[k-1];
      end
    end
  end

  task automatic tick(input logic e, input logic s, input logic c, input string tag);
    @(negedge clk);
    checks++;
    if (snap_vld !== h_stb[TW-1]) begin
      fails++;
      $display("FAIL %s R4 valid: act=%0b exp=%0b", tag, snap_vld, h_stb[TW-1]);
    end
    checks++;
    if (snap_val !== exp_hold) begin
      fails++;
      $display("FAIL %s R1 R8 value: act=%0d exp=%0d", tag, snap_val, exp_hold);
    end
    en = e;
    snap_req = s;
    clr = c;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) tick(1'b0, 1'b0, 1'b1, "R6 reset");
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b0, 1'b0, "R6 reset");
  endtask

  task automatic t_steady();
    for (int k = 0; k < 40; k++) tick(1'b1, (k % 7) == 3, 1'b0, "R1 R2 steady");
    for (int k = 0; k < TW + 2; k++) tick(1'b0, 1'b0, 1'b0, "R1 R2 steady");
  endtask

  task automatic t_gated();
    for (int k = 0; k < 45; k++) tick((k % 3) == 0, (k % 5) == 1, 1'b0, "R9 R2 gated");
    for (int k = 0; k < 6; k++) tick(1'b0, 1'b1, 1'b0, "R9 frozen");
    for (int k = 0; k < TW + 2; k++) tick(1'b0, 1'b0, 1'b0, "R9 frozen");
  endtask

  task automatic t_b2b();
    for (int k = 0; k < 6; k++) tick(1'b1, 1'b1, 1'b0, "R5 back-to-back");
    for (int k = 0; k < TW + 4; k++) tick(1'b1, 1'b0, 1'b0, "R5 back-to-back");
  endtask

  task automatic t_wrap();
    tick(1'b0, 1'b0, 1'b1, "R7 wrap");
    for (int k = 0; k < 300; k++)
      tick(1'b1, (k >= 125 && k <= 130) || (k >= 252 && k <= 259), 1'b0, "R7 R3 wrap");
    for (int k = 0; k < TW + 2; k++) tick(1'b0, 1'b0, 1'b0, "R7 R3 wrap");
  endtask

  task automatic t_flush();
    tick(1'b1, 1'b1, 1'b0, "R6 flush");
    for (int k = 0; k < 3; k++) tick(1'b1, 1'b0, 1'b0, "R6 flush");
    tick(1'b1, 1'b1, 1'b1, "R6 flush");
    for (int k = 0; k < TW + 3; k++) tick(1'b1, 1'b0, 1'b0, "R6 flush");
  endtask

  task automatic t_hold();
    tick(1'b1, 1'b1, 1'b0, "R8 hold");
    for (int k = 0; k < 3 * TW; k++) tick(1'b1, 1'b0, 1'b0, "R8 hold");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog: act=%0d cycles exp=<%0d", 50000, 50000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_steady();
    t_gated();
    t_b2b();
    t_wrap();
    t_flush();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule